// File: doc/BRIEF.md
# Key Matrix Emulator with Paced Event Queue

This block stands in for a passive grid of keys that a host scans. The host drives one strobe line per column and reads one sense line per row. A sense line is high whenever a key held down in that row sits on a column whose strobe is asserted. Sense follows the strobes with no clock delay, so a host may change a strobe and read the rows in the same cycle.

Key events arrive as 8-bit codes. Bit 7 set marks a release and bit 7 clear marks a press. Each code first enters a 16-entry circular queue. A free-running tick generator releases one queued event per tick. The event's low seven bits index a 128-entry translation table that gives a grid position, encoded as `(row << 4) | column`. Rows 0 to 6 are the real grid. Row 7 is a virtual row: its column number picks one of five stand-alone level outputs, and the grid is left alone. The table is loaded through a small write port and comes out of reset as all-ones, which means "unmapped".

A clear input releases every key and empties the queue in one cycle. It leaves the special outputs and the overflow flag as they are.

Top module: `keymatrix_emu`

## Requirements
- R1: While reset is low, and after it is released, sense_o is 0, special_o is 0, overflow_o is 0, the queue is empty and every table entry is 8'hFF.
- R2: sense_o[r] is 1 exactly when the AND of row r's pressed-key mask and strobe_i is nonzero. The output is combinational, so it changes in the same cycle as strobe_i.
- R3: The tick generator fires every TICK_CYCLES cycles. The first tick comes in the TICK_CYCLES-th cycle after reset is released. On each tick at most one event leaves the queue, in arrival order, and its effect is visible after that clock edge.
- R4: A dequeued code indexes the table with bits [6:0]. If bit 7 is 0 the key's mask bit is set (press). If bit 7 is 1 the mask bit is cleared (release).
- R5: A table entry is read as row = bits [7:4] and column = bits [3:0]. If row < 7 and column < 11, the event acts on the grid. Any other entry, including 8'hFF, drops the event with no effect on any output.
- R6: An entry with row = 7 and column < 5 drives special_o[column] to 1 on press and to 0 on release, and leaves the grid unchanged. special_o changes only on a tick.
- R7: The queue holds 16 events. A push made while 16 events are already held is dropped and sets overflow_o. overflow_o stays set until reset, even if an event leaves the queue in the same cycle.
- R8: When clear_i is high at a clock edge, all grid masks become 0 and the queue becomes empty. A push or a tick in that same cycle has no effect. special_o and overflow_o are unchanged.
- R9: When lut_we_i is high, lut_data_i is written to table entry lut_addr_i at the clock edge. Events that leave the queue in later cycles use the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 11 | Column strobes driven by the scanning host |
| ev_valid_i | input | 1 | Push ev_code_i into the event queue |
| ev_code_i | input | 8 | Key event: bit 7 = release, bits 6:0 = table index |
| lut_we_i | input | 1 | Write enable for the translation table |
| lut_addr_i | input | 7 | Translation table entry address |
| lut_data_i | input | 8 | Grid position to store, (row<<4) or column |
| clear_i | input | 1 | Release all keys and empty the queue |
| sense_o | output | 7 | Row sense lines |
| special_o | output | 5 | Level outputs of the virtual row |
| overflow_o | output | 1 | Sticky flag: a push was lost to a full queue |

## Verification
The assertions check on every cycle that a grid with no strobes reads all zero, and that a fully strobed grid with any key held reads nonzero. They also check that the masks and the special outputs move only on a tick or a clear, that one tick changes at most one key, that a clear leaves every mask empty, and that the overflow flag is sticky. The bench's reference model adds the full picture on every clock. That covers queue order and the pacing of one event per tick, table translation and dropped codes, the wrap of the circular indices, the limit of 16 entries, and a clear that races a push or a tick. None of these can be seen through single-cycle properties.

// File: rtl/kmx_pkg.sv
// Package: shared constants and the packed grid-position type for the
// key matrix emulator. Assumes 8-bit event codes with the release flag on top.
package kmx_pkg;
    localparam int KMX_CODE_W   = 8;
    localparam int KMX_IDX_W    = KMX_CODE_W - 1;
    localparam int KMX_REL_BIT  = KMX_CODE_W - 1;
    localparam logic [KMX_CODE_W-1:0] KMX_UNMAPPED = '1;

    // Grid position as stored in the translation table
    typedef struct packed {
        logic [3:0] row;
        logic [3:0] col;
    } kmx_pos_t;
endpackage

// File: rtl/kmx_tick_gen.sv
// Module: free-running pacing counter. It gives a one-cycle tick every
// TICK_CYCLES clocks. Assumes TICK_CYCLES >= 2.
module kmx_tick_gen #(
    parameter int TICK_CYCLES = 7812500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(TICK_CYCLES);

    logic [CW-1:0] cnt;

    assign tick_o = (cnt == CW'(TICK_CYCLES - 1));

    // Count up and wrap when the tick fires
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/kmx_event_fifo.sv
// Module: circular event queue with wrapping read and write indices.
// A push while full is dropped and sets a sticky overflow flag. Flush
// empties the queue and wins over a push or pop in the same cycle.
module kmx_event_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    input  logic         flush_i,
    output logic [W-1:0] head_o,
    output logic         head_valid_o,
    output logic         overflow_o
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_push, do_pop;

    assign full         = (count == CNT_W'(DEPTH));
    assign head_valid_o = (count != '0);
    assign head_o       = mem[rd_ptr];
    assign do_push      = push_i && !full && !flush_i;
    assign do_pop       = pop_i && head_valid_o && !flush_i;

    // Store accepted events at the write index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_push) begin
            mem[wr_ptr] <= push_data_i;
        end
    end

    // Advance the indices and the occupancy count, wrapping at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (!do_push && do_pop) count <= count - 1'b1;
        end
    end

    // Latch a lost push until reset
    always_ff @(posedge clk) begin
        if (!rst_n)                              overflow_o <= 1'b0;
        else if (push_i && full && !flush_i)     overflow_o <= 1'b1;
    end
endmodule

// File: rtl/kmx_lut.sv
// Module: code-to-position translation table. Asynchronous read and
// synchronous write. Every entry resets to the unmapped code.
module kmx_lut #(
    parameter int IDX_W = 7,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output logic [W-1:0]     rdata_o
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [W-1:0] table_q [ENTRIES];

    assign rdata_o = table_q[raddr_i];

    // Reset to unmapped, then accept writes from the load port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) table_q[i] <= '1;
        end else if (we_i) begin
            table_q[waddr_i] <= wdata_i;
        end
    end
endmodule

// File: rtl/kmx_matrix.sv
// Module: pressed-key state. It holds one column mask per grid row and
// the levels of the virtual row. It applies one translated event when
// apply_i is high. Clear empties the grid but keeps the special levels.
module kmx_matrix
    import kmx_pkg::*;
#(
    parameter int N_ROWS    = 7,
    parameter int N_COLS    = 11,
    parameter int N_SPECIAL = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     apply_i,
    input  logic                     release_i,
    input  kmx_pos_t                 pos_i,
    input  logic                     clear_i,
    output logic [N_ROWS*N_COLS-1:0] mask_flat_o,
    output logic [N_SPECIAL-1:0]     special_o
);
    localparam logic [3:0] ROW_LIM  = 4'(N_ROWS);
    localparam logic [3:0] COL_LIM  = 4'(N_COLS);
    localparam logic [3:0] SPEC_LIM = 4'(N_SPECIAL);
    localparam logic [3:0] SPEC_ROW = 4'(N_ROWS);

    logic                 is_key, is_spec;
    logic [N_COLS-1:0]    col_bit;
    logic [N_SPECIAL-1:0] spec_bit;

    // Classify the position and form one-hot selects
    always_comb begin
        is_key   = apply_i && (pos_i.row < ROW_LIM) && (pos_i.col < COL_LIM);
        is_spec  = apply_i && (pos_i.row == SPEC_ROW) && (pos_i.col < SPEC_LIM);
        col_bit  = {{(N_COLS-1){1'b0}}, 1'b1} << pos_i.col;
        spec_bit = {{(N_SPECIAL-1){1'b0}}, 1'b1} << pos_i.col;
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        logic [N_COLS-1:0] mask_q;
        logic              hit;

        assign hit = is_key && (pos_i.row == 4'(r));
        assign mask_flat_o[r*N_COLS +: N_COLS] = mask_q;

        // Set or clear this row's key bit, or empty the row on clear
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) mask_q <= '0;
            else if (hit)          mask_q <= release_i ? (mask_q & ~col_bit)
                                                       : (mask_q | col_bit);
        end
    end

    // Drive the selected virtual-row level: high on press, low on release
    always_ff @(posedge clk) begin
        if (!rst_n)                 special_o <= '0;
        else if (is_spec && !clear_i)
            special_o <= release_i ? (special_o & ~spec_bit)
                                   : (special_o | spec_bit);
    end
endmodule

// File: rtl/keymatrix_emu.sv
// Module: top of the key matrix emulator. It queues key events, releases
// one per tick through the translation table into the key state, and
// forms the row sense lines from the key state and the live strobes.
module keymatrix_emu
    import kmx_pkg::*;
#(
    parameter int N_ROWS      = 7,
    parameter int N_COLS      = 11,
    parameter int N_SPECIAL   = 5,
    parameter int Q_DEPTH     = 16,
    parameter int TICK_CYCLES = 7812500
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_COLS-1:0]     strobe_i,
    input  logic                  ev_valid_i,
    input  logic [KMX_CODE_W-1:0] ev_code_i,
    input  logic                  lut_we_i,
    input  logic [KMX_IDX_W-1:0]  lut_addr_i,
    input  logic [KMX_CODE_W-1:0] lut_data_i,
    input  logic                  clear_i,
    output logic [N_ROWS-1:0]     sense_o,
    output logic [N_SPECIAL-1:0]  special_o,
    output logic                  overflow_o
);
    logic                     tick;
    logic [KMX_CODE_W-1:0]    head;
    logic                     head_valid;
    logic                     apply;
    logic [KMX_CODE_W-1:0]    entry;
    logic [N_ROWS*N_COLS-1:0] mask_flat;

    assign apply = tick && head_valid && !clear_i;

    kmx_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    kmx_event_fifo #(.DEPTH(Q_DEPTH), .W(KMX_CODE_W)) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (ev_valid_i),
        .push_data_i  (ev_code_i),
        .pop_i        (tick),
        .flush_i      (clear_i),
        .head_o       (head),
        .head_valid_o (head_valid),
        .overflow_o   (overflow_o)
    );

    kmx_lut #(.IDX_W(KMX_IDX_W), .W(KMX_CODE_W)) u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lut_we_i),
        .waddr_i (lut_addr_i),
        .wdata_i (lut_data_i),
        .raddr_i (head[KMX_IDX_W-1:0]),
        .rdata_o (entry)
    );

    kmx_matrix #(.N_ROWS(N_ROWS), .N_COLS(N_COLS), .N_SPECIAL(N_SPECIAL)) u_matrix (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply_i     (apply),
        .release_i   (head[KMX_REL_BIT]),
        .pos_i       (kmx_pos_t'(entry)),
        .clear_i     (clear_i),
        .mask_flat_o (mask_flat),
        .special_o   (special_o)
    );

    // Row sense: any held key of the row on a driven column
    for (genvar r = 0; r < N_ROWS; r++) begin : g_sense
        assign sense_o[r] = |(mask_flat[r*N_COLS +: N_COLS] & strobe_i);
    end
endmodule

// File: rtl/kmx_checker.sv
// Module: property checker for the key matrix emulator, bound to the top.
// It observes ports plus the tick and the flattened key state.
module kmx_checker #(
    parameter int N_ROWS    = 7,
    parameter int N_COLS    = 11,
    parameter int N_SPECIAL = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_COLS-1:0]        strobe_i,
    input logic                     clear_i,
    input logic [N_ROWS-1:0]        sense_o,
    input logic [N_SPECIAL-1:0]     special_o,
    input logic                     overflow_o,
    input logic                     tick,
    input logic [N_ROWS*N_COLS-1:0] mask_flat
);
    // R1: reset leaves every output and key bit at zero
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (special_o == '0 && !overflow_o && mask_flat == '0));

    // R2: no strobe, no sense
    assert_sense_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i == '0) |-> (sense_o == '0));

    // R2: all strobes driven with any key held must show a row
    assert_sense_any_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i == '1 && mask_flat != '0) |-> (sense_o != '0));

    // R3: key state moves only on a tick or a clear
    assert_keys_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear_i) |=> $stable(mask_flat));

    // R4: a single tick changes at most one key
    assert_one_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear_i) |=> ($countones(mask_flat ^ $past(mask_flat)) <= 1));

    // R6: special levels move only on a tick
    assert_special_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(special_o));

    // R7: overflow is sticky
    assert_no_overflow_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R8: clear empties every row
    assert_clear_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (mask_flat == '0));
endmodule

bind keymatrix_emu kmx_checker #(
    .N_ROWS    (N_ROWS),
    .N_COLS    (N_COLS),
    .N_SPECIAL (N_SPECIAL)
) u_kmx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (strobe_i),
    .clear_i    (clear_i),
    .sense_o    (sense_o),
    .special_o  (special_o),
    .overflow_o (overflow_o),
    .tick       (tick),
    .mask_flat  (mask_flat)
);

// File: tb/keymatrix_emu_tb.sv
// Bench: behavioural reference model compared every clock, plus directed
// scenarios with literal expectations for each requirement.
module keymatrix_emu_tb;
    localparam int TICK  = 6;
    localparam int DEPTH = 16;
    localparam int NR = 7, NC = 11, NS = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] strobe_i = '0;
    logic          ev_valid_i = 1'b0;
    logic [7:0]    ev_code_i = '0;
    logic          lut_we_i = 1'b0;
    logic [6:0]    lut_addr_i = '0;
    logic [7:0]    lut_data_i = '0;
    logic          clear_i = 1'b0;
    logic [NR-1:0] sense_o;
    logic [NS-1:0] special_o;
    logic          overflow_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    keymatrix_emu #(.TICK_CYCLES(TICK), .Q_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i),
        .ev_valid_i(ev_valid_i), .ev_code_i(ev_code_i),
        .lut_we_i(lut_we_i), .lut_addr_i(lut_addr_i), .lut_data_i(lut_data_i),
        .clear_i(clear_i), .sense_o(sense_o), .special_o(special_o),
        .overflow_o(overflow_o)
    );

    // ---------------- reference model ----------------
    int            mq[$];
    logic [7:0]    mlut [128];
    logic [NC-1:0] mmask [NR];
    logic [NS-1:0] mspec;
    bit            movf;
    int            mcnt;
    bit            mtick, mfull;

    task automatic model_apply(input int code);
        int e, row, col;
        e   = int'(mlut[code & 'h7f]);
        row = e >> 4;
        col = e & 'hf;
        if (row < NR && col < NC) begin
            if (code & 'h80) mmask[row][col] = 1'b0;
            else             mmask[row][col] = 1'b1;
        end else if (row == NR && col < NS) begin
            mspec[col] = ((code & 'h80) == 0);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mlut[i] = 8'hFF;
            for (int r = 0; r < NR; r++) mmask[r] = '0;
            mspec = '0; movf = 0; mcnt = 0; mq.delete();
        end else begin
            mtick = (mcnt == TICK - 1);
            mcnt  = mtick ? 0 : mcnt + 1;
            mfull = (mq.size() == DEPTH);
            if (!clear_i && mtick && mq.size() > 0) model_apply(mq.pop_front());
            if (lut_we_i) mlut[lut_addr_i] = lut_data_i;
            if (!clear_i && ev_valid_i) begin
                if (mfull) movf = 1;
                else       mq.push_back(int'(ev_code_i));
            end
            if (clear_i) begin
                mq.delete();
                for (int r = 0; r < NR; r++) mmask[r] = '0;
            end
        end
    end

    function automatic logic [NR-1:0] model_sense();
        logic [NR-1:0] s;
        for (int r = 0; r < NR; r++) s[r] = |(mmask[r] & strobe_i);
        return s;
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (sense_o !== model_sense()) begin
                bad++;
                $display("FAIL R2 R3 cycle sense actual=%b expected=%b", sense_o, model_sense());
            end
            total++;
            if (special_o !== mspec) begin
                bad++;
                $display("FAIL R6 cycle special actual=%b expected=%b", special_o, mspec);
            end
            total++;
            if (overflow_o !== movf) begin
                bad++;
                $display("FAIL R7 cycle overflow actual=%b expected=%b", overflow_o, movf);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic push(input logic [7:0] c);
        ev_valid_i = 1'b1; ev_code_i = c; cyc(1); ev_valid_i = 1'b0;
    endtask

    task automatic lut_wr(input logic [6:0] a, input logic [7:0] d);
        lut_we_i = 1'b1; lut_addr_i = a; lut_data_i = d; cyc(1); lut_we_i = 1'b0;
    endtask

    task automatic drain();
        cyc((DEPTH + 1) * TICK + 4);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_sense(input string req, input logic [NC-1:0] s, input logic [NR-1:0] exp);
        strobe_i = s;
        @(negedge clk);
        check(req, int'(sense_o), int'(exp));
        @(posedge clk); #1;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        int t0, t6, cyc_i;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);

        // R1: reset state
        @(negedge clk);
        check("R1 special after reset", int'(special_o), 0);
        check("R1 overflow after reset", int'(overflow_o), 0);
        @(posedge clk); #1;
        chk_sense("R1 sense after reset", '1, 7'b0);

        // R1 R5: table starts unmapped, so a press is dropped
        push(8'h10); drain();
        chk_sense("R1 R5 unmapped press dropped", '1, 7'b0);

        // Load translation table (R9 port)
        lut_wr(7'h10, 8'h23);   // row 2 col 3
        lut_wr(7'h11, 8'h00);   // row 0 col 0
        lut_wr(7'h12, 8'h6A);   // row 6 col 10
        lut_wr(7'h20, 8'h24);   // row 2 col 4
        lut_wr(7'h13, 8'h72);   // special 2
        lut_wr(7'h14, 8'h7F);   // special col out of range
        lut_wr(7'h15, 8'h0C);   // column 12 out of range
        lut_wr(7'h16, 8'h83);   // row 8 out of range

        // R4: press sets the bit; R2: only the matching strobe senses
        push(8'h10); drain();
        chk_sense("R4 press row2 col3", 11'(1 << 3), 7'b0000100);
        chk_sense("R2 other column no sense", 11'(1 << 4), 7'b0);
        chk_sense("R2 all strobes", '1, 7'b0000100);

        // R2: several rows and columns
        push(8'h11); push(8'h12); push(8'h20); drain();
        chk_sense("R2 col10 row6", 11'(1 << 10), 7'b1000000);
        chk_sense("R2 cols 0 and 4", 11'((1 << 0) | (1 << 4)), 7'b0000101);
        chk_sense("R2 no strobe", '0, 7'b0);

        // R4: release via bit 7 clears only its own key
        push(8'h90); drain();
        chk_sense("R4 released col3", 11'(1 << 3), 7'b0);
        chk_sense("R4 col4 still held", 11'(1 << 4), 7'b0000100);

        // R5: out-of-range entries drop events
        push(8'h14); push(8'h15); push(8'h16); drain();
        chk_sense("R5 dropped entries leave grid", '1, 7'b1000101);
        @(negedge clk);
        check("R5 dropped entries leave special", int'(special_o), 0);
        @(posedge clk); #1;

        // R6: virtual row drives special output, grid untouched
        push(8'h13); drain();
        @(negedge clk);
        check("R6 special press", int'(special_o), 5'b00100);
        @(posedge clk); #1;
        chk_sense("R6 grid unchanged by special", '1, 7'b1000101);
        push(8'h93); drain();
        @(negedge clk);
        check("R6 special release", int'(special_o), 0);
        @(posedge clk); #1;

        // R3: two back-to-back releases take effect exactly one tick apart
        strobe_i = '1;
        push(8'h91); push(8'h92);
        t0 = -1; t6 = -1;
        for (int k = 0; k < 4 * TICK; k++) begin
            @(negedge clk);
            if (t0 < 0 && !sense_o[0]) t0 = k;
            if (t6 < 0 && !sense_o[6]) t6 = k;
        end
        @(posedge clk); #1;
        check("R3 one event per tick spacing", t6 - t0, TICK);
        check("R3 first event seen", int'(t0 >= 0), 1);

        // R7: flood the queue with unmapped codes
        for (int k = 0; k < 30; k++) push(8'h7E);
        @(negedge clk);
        check("R7 overflow set", int'(overflow_o), 1);
        @(posedge clk); #1;
        drain();
        @(negedge clk);
        check("R7 overflow sticky", int'(overflow_o), 1);
        @(posedge clk); #1;

        // R8: clear with keys held and events queued, push in same cycle
        push(8'h13); push(8'h10); drain();
        push(8'h11); push(8'h12);
        clear_i = 1'b1; ev_valid_i = 1'b1; ev_code_i = 8'h11;
        cyc(1);
        clear_i = 1'b0; ev_valid_i = 1'b0;
        drain();
        chk_sense("R8 clear released all keys and queue", '1, 7'b0);
        @(negedge clk);
        check("R8 special kept", int'(special_o), 5'b00100);
        check("R8 overflow kept", int'(overflow_o), 1);
        @(posedge clk); #1;

        // R9: rewrite a table entry and use it
        lut_wr(7'h10, 8'h31);
        push(8'h10); drain();
        chk_sense("R9 remapped row3 col1", 11'(1 << 1), 7'b0001000);
        chk_sense("R9 old position unused", 11'(1 << 3), 7'b0);

        cyc_i = 0;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad + cyc_i);
        $finish;
    end
endmodule